// File: doc/BRIEF.md
# Flash block erase sequencer

This controller erases a chosen set of flash blocks and then checks each one, with no software stepping it through the phases. A one-cycle start pulse latches a block mask. The controller raises software-write enable. After a programmed delay it selects the lowest pending block, arms an external watchdog and opens erase setup. It then fires one erase pulse of fixed length. After the pulse it steps back through timed hold-offs, clears the watchdog and enters erase-verify mode.

In verify mode the sequencer walks through the words of the block. For each word it makes a dummy write of all ones to the word's address and, a fixed time later, reads the word back as a 16-bit value. A word that reads all ones passes and the walk moves to the next address. A word with any zero bit sends the block back through another erase pulse. Verification then restarts at the word that failed, not at the start of the block. Each block is allowed a limited number of erase pulses, and using them all without a clean pass ends the operation with a fail pulse. When every selected block passes, write enable drops and a done pulse is given. Blocks are not written to zero before erasing. Every delay is a parameter counted in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, every control output, the block select, the address-related strobes, the watchdog pulses and busy, done and fail are all 0.
- R2: A start pulse with a nonzero mask raises write enable (`fl_swe_o`) on the next clock edge. Exactly T_SWE_SEL cycles later, the one-hot block select shows the lowest set bit of the mask. The block select is never more than one-hot, and setup, erase, verify and the watchdog pulses occur only while write enable is high.
- R3: Each time a block is selected, and each time a block is re-erased, `wdt_arm_o` pulses for one cycle. Erase setup (`fl_esu_o`) rises in the following cycle.
- R4: The erase pulse (`fl_ers_o`) rises exactly T_ESU_ERS cycles after erase setup rises. It stays high for exactly T_ERS cycles, never more than T_ERS_MAX, and it is high only while erase setup is high.
- R5: Erase setup falls T_ERS_ESU cycles after the erase pulse falls. T_ESU_CLR cycles after that, `wdt_clr_o` pulses for one cycle, and verify mode (`fl_ev_o`) rises in the same cycle. Verify mode is never high together with erase setup or erase.
- R6: Each dummy write (`fl_dwr_o`) is a one-cycle pulse made in verify mode, with `fl_wdata_o` at 16'hFFFF. It comes T_EV_DWR cycles after verify mode rises, or T_EV_DWR+1 cycles after the previous read strobe. The read strobe (`fl_rd_o`) follows T_DWR_RD cycles after the dummy write, at the same address. The address is block_index*WORDS + word.
- R7: A read value of 16'hFFFF passes. The next dummy write goes to the next address. After the last word of a block passes, verify mode falls in the following cycle.
- R8: A read with any bit at 0 drops verify mode in the following cycle. T_EV_EXIT cycles later the block is re-armed and erased again, and the first dummy write after that re-erase is at the failing address.
- R9: At most N_ERASE erase pulses are issued per block. A failing read after the N_ERASE-th pulse drops all controls and the block select in the following cycle, pulses `fail_o` for one cycle and ends busy. It gives no done pulse.
- R10: Selected blocks are processed in ascending index order, and unselected blocks never see an erase pulse. T_EV_EXIT cycles after verify mode falls on a passing block, the next block is selected; after the last block, write enable falls and `done_o` pulses in that same cycle.
- R11: A start pulse while busy has no effect. A start with an all-zero mask pulses `done_o` on the next edge without raising write enable or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request |
| blk_mask_i | input | NBLK | Blocks to erase, sampled with start |
| fl_rdata_i | input | DW | Verify read data from the array |
| fl_swe_o | output | 1 | Software-write enable |
| fl_esu_o | output | 1 | Erase setup |
| fl_ers_o | output | 1 | Erase pulse |
| fl_ev_o | output | 1 | Erase-verify mode |
| fl_blk_sel_o | output | NBLK | One-hot block select |
| fl_dwr_o | output | 1 | Dummy-write strobe |
| fl_rd_o | output | 1 | Verify read strobe |
| fl_addr_o | output | AW | Word address |
| fl_wdata_o | output | DW | Dummy-write data |
| wdt_arm_o | output | 1 | Watchdog arm pulse |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
A wrong phase state or wrong timer load shows up at once as a shifted edge on the next control that changes, so every gap between control edges is measured against its parameter. A wrong word pointer after a re-erase appears at the first dummy write that follows, as an address other than the failing word. A wrong pending mask or retry count shows later, at the end of the block: as the wrong next block select, an extra or missing erase pulse, or done in place of fail. The behavioural array counts erase pulses per block, so such end-of-block errors are exposed within one block pass.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_WSEL  = 4'd1,
        S_ARM   = 4'd2,
        S_WESU  = 4'd3,
        S_WERS  = 4'd4,
        S_WH1   = 4'd5,
        S_WH2   = 4'd6,
        S_WDWR  = 4'd7,
        S_WRD   = 4'd8,
        S_CHK   = 4'd9,
        S_WEXIT = 4'd10
    } fes_state_e;

endpackage

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fes_lowest_pick.sv
module fes_lowest_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant_o[g]  = req_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_i[g];
    end

    assign any_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int WORDS     = 8,
    parameter int DW        = 16,
    parameter int N_ERASE   = 3,
    parameter int T_SWE_SEL = 5,
    parameter int T_ESU_ERS = 4,
    parameter int T_ERS     = 12,
    parameter int T_ERS_MAX = 16,
    parameter int T_ERS_ESU = 3,
    parameter int T_ESU_CLR = 3,
    parameter int T_EV_DWR  = 2,
    parameter int T_DWR_RD  = 3,
    parameter int T_EV_EXIT = 4,
    localparam int AW       = $clog2(NBLK * WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NBLK-1:0] blk_mask_i,
    input  logic [DW-1:0]   fl_rdata_i,
    output logic            fl_swe_o,
    output logic            fl_esu_o,
    output logic            fl_ers_o,
    output logic            fl_ev_o,
    output logic [NBLK-1:0] fl_blk_sel_o,
    output logic            fl_dwr_o,
    output logic            fl_rd_o,
    output logic [AW-1:0]   fl_addr_o,
    output logic [DW-1:0]   fl_wdata_o,
    output logic            wdt_arm_o,
    output logic            wdt_clr_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            fail_o
);

    localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam int WW   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int CW   = $clog2(N_ERASE + 1);
    localparam int DSUM = T_SWE_SEL + T_ESU_ERS + T_ERS + T_ERS_ESU
                        + T_ESU_CLR + T_EV_DWR + T_DWR_RD + T_EV_EXIT;
    localparam int TW   = $clog2(DSUM + 1);
    localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);
    localparam logic [CW-1:0] MAX_ERASE = CW'(N_ERASE);

    typedef struct packed {
        fes_state_e      st;
        logic            swe;
        logic            esu;
        logic            ers;
        logic            ev;
        logic [NBLK-1:0] sel;
        logic [NBLK-1:0] pend;
        logic [BW-1:0]   idx;
        logic [WW-1:0]   word;
        logic [CW-1:0]   ecnt;
        logic            pass;
        logic            dwr;
        logic            rd;
        logic            arm;
        logic            clr;
        logic            done;
        logic            fail;
    } seq_t;

    seq_t r_d, r_q;

    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_zero;
    logic [NBLK-1:0] pk_grant;
    logic [BW-1:0]   pk_idx;
    logic            pk_any;
    logic            word_ok;

    fes_lowest_pick #(
        .N  (NBLK),
        .IW (BW)
    ) u_pick (
        .req_i   (r_q.pend),
        .grant_o (pk_grant),
        .idx_o   (pk_idx),
        .any_o   (pk_any)
    );

    fes_wait_timer #(
        .TW (TW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    assign word_ok = (fl_rdata_i == {DW{1'b1}});

    always_comb begin
        r_d      = r_q;
        r_d.dwr  = 1'b0;
        r_d.rd   = 1'b0;
        r_d.arm  = 1'b0;
        r_d.clr  = 1'b0;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;

        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (blk_mask_i == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.swe  = 1'b1;
                        r_d.pend = blk_mask_i;
                        r_d.st   = S_WSEL;
                        t_load   = 1'b1;
                        t_val    = TW'(T_SWE_SEL - 1);
                    end
                end
            end

            S_WSEL: begin
                if (t_zero) begin
                    r_d.sel  = pk_grant;
                    r_d.idx  = pk_idx;
                    r_d.pend = r_q.pend & ~pk_grant;
                    r_d.word = '0;
                    r_d.ecnt = '0;
                    r_d.arm  = 1'b1;
                    r_d.st   = S_ARM;
                end
            end

            S_ARM: begin
                r_d.esu = 1'b1;
                r_d.st  = S_WESU;
                t_load  = 1'b1;
                t_val   = TW'(T_ESU_ERS - 1);
            end

            S_WESU: begin
                if (t_zero) begin
                    r_d.ers  = 1'b1;
                    r_d.ecnt = r_q.ecnt + 1'b1;
                    r_d.st   = S_WERS;
                    t_load   = 1'b1;
                    t_val    = TW'(T_ERS - 1);
                end
            end

            S_WERS: begin
                if (t_zero) begin
                    r_d.ers = 1'b0;
                    r_d.st  = S_WH1;
                    t_load  = 1'b1;
                    t_val   = TW'(T_ERS_ESU - 1);
                end
            end

            S_WH1: begin
                if (t_zero) begin
                    r_d.esu = 1'b0;
                    r_d.st  = S_WH2;
                    t_load  = 1'b1;
                    t_val   = TW'(T_ESU_CLR - 1);
                end
            end

            S_WH2: begin
                if (t_zero) begin
                    r_d.clr = 1'b1;
                    r_d.ev  = 1'b1;
                    r_d.st  = S_WDWR;
                    t_load  = 1'b1;
                    t_val   = TW'(T_EV_DWR - 1);
                end
            end

            S_WDWR: begin
                if (t_zero) begin
                    r_d.dwr = 1'b1;
                    r_d.st  = S_WRD;
                    t_load  = 1'b1;
                    t_val   = TW'(T_DWR_RD - 1);
                end
            end

            S_WRD: begin
                if (t_zero) begin
                    r_d.rd = 1'b1;
                    r_d.st = S_CHK;
                end
            end

            S_CHK: begin
                if (word_ok) begin
                    if (r_q.word == LAST_WORD) begin
                        r_d.ev   = 1'b0;
                        r_d.pass = 1'b1;
                        r_d.st   = S_WEXIT;
                        t_load   = 1'b1;
                        t_val    = TW'(T_EV_EXIT - 1);
                    end else begin
                        r_d.word = r_q.word + 1'b1;
                        r_d.st   = S_WDWR;
                        t_load   = 1'b1;
                        t_val    = TW'(T_EV_DWR - 1);
                    end
                end else if (r_q.ecnt >= MAX_ERASE) begin
                    r_d.ev   = 1'b0;
                    r_d.swe  = 1'b0;
                    r_d.sel  = '0;
                    r_d.pend = '0;
                    r_d.fail = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.ev   = 1'b0;
                    r_d.pass = 1'b0;
                    r_d.st   = S_WEXIT;
                    t_load   = 1'b1;
                    t_val    = TW'(T_EV_EXIT - 1);
                end
            end

            S_WEXIT: begin
                if (t_zero) begin
                    if (!r_q.pass) begin
                        r_d.arm = 1'b1;
                        r_d.st  = S_ARM;
                    end else if (pk_any) begin
                        r_d.sel  = pk_grant;
                        r_d.idx  = pk_idx;
                        r_d.pend = r_q.pend & ~pk_grant;
                        r_d.word = '0;
                        r_d.ecnt = '0;
                        r_d.arm  = 1'b1;
                        r_d.st   = S_ARM;
                    end else begin
                        r_d.swe  = 1'b0;
                        r_d.sel  = '0;
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end
            end

            default: begin
                r_d    = '0;
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fl_swe_o     = r_q.swe;
    assign fl_esu_o     = r_q.esu;
    assign fl_ers_o     = r_q.ers;
    assign fl_ev_o      = r_q.ev;
    assign fl_blk_sel_o = r_q.sel;
    assign fl_dwr_o     = r_q.dwr;
    assign fl_rd_o      = r_q.rd;
    assign fl_addr_o    = AW'(r_q.idx) * AW'(WORDS) + AW'(r_q.word);
    assign fl_wdata_o   = r_q.dwr ? {DW{1'b1}} : {DW{1'b0}};
    assign wdt_arm_o    = r_q.arm;
    assign wdt_clr_o    = r_q.clr;
    assign busy_o       = (r_q.st != S_IDLE);
    assign done_o       = r_q.done;
    assign fail_o       = r_q.fail;

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int NBLK      = 4,
    parameter int DW        = 16,
    parameter int T_ESU_ERS = 4,
    parameter int T_ERS_MAX = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fl_swe_o,
    input logic            fl_esu_o,
    input logic            fl_ers_o,
    input logic            fl_ev_o,
    input logic [NBLK-1:0] fl_blk_sel_o,
    input logic            fl_dwr_o,
    input logic [DW-1:0]   fl_wdata_o,
    input logic            wdt_arm_o,
    input logic            wdt_clr_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            fail_o
);

    logic [15:0] esu_cnt_q;
    logic [15:0] ers_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esu_cnt_q <= '0;
            ers_cnt_q <= '0;
        end else begin
            if (!fl_esu_o) begin
                esu_cnt_q <= '0;
            end else if (!fl_ers_o && esu_cnt_q != 16'hFFFF) begin
                esu_cnt_q <= esu_cnt_q + 1'b1;
            end
            if (!fl_ers_o) begin
                ers_cnt_q <= '0;
            end else if (ers_cnt_q != 16'hFFFF) begin
                ers_cnt_q <= ers_cnt_q + 1'b1;
            end
        end
    end

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_blk_sel_o));

    assert_ctrl_needs_swe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_esu_o || fl_ev_o || wdt_arm_o || wdt_clr_o) |-> fl_swe_o);

    assert_esu_after_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_arm_o |=> fl_esu_o);

    assert_ers_inside_esu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ers_o |-> fl_esu_o);

    assert_setup_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ers_o) |-> (esu_cnt_q >= 16'(T_ESU_ERS)));

    assert_ers_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ers_cnt_q <= 16'(T_ERS_MAX));

    assert_ev_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ev_o |-> (!fl_esu_o && !fl_ers_o));

    assert_dwr_in_ev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dwr_o |-> (fl_ev_o && fl_wdata_o == {DW{1'b1}}));

    assert_end_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!fl_swe_o && !busy_o && fl_blk_sel_o == '0));

endmodule

bind flash_erase_seq fes_checker #(
    .NBLK      (NBLK),
    .DW        (DW),
    .T_ESU_ERS (T_ESU_ERS),
    .T_ERS_MAX (T_ERS_MAX)
) u_fes_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fl_swe_o     (fl_swe_o),
    .fl_esu_o     (fl_esu_o),
    .fl_ers_o     (fl_ers_o),
    .fl_ev_o      (fl_ev_o),
    .fl_blk_sel_o (fl_blk_sel_o),
    .fl_dwr_o     (fl_dwr_o),
    .fl_wdata_o   (fl_wdata_o),
    .wdt_arm_o    (wdt_arm_o),
    .wdt_clr_o    (wdt_clr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
);

// File: tb/flash_erase_seq_bench.sv
`timescale 1ns/1ps
module flash_erase_seq_bench;

    localparam int NBLK = 4, WORDS = 8, DW = 16, NE = 3;
    localparam int TX = 5, TY = 4, TE = 12, TZ = 16, TH1 = 3, TH2 = 3;
    localparam int TDW = 2, TRD = 3, TEX = 4;
    localparam int AW = $clog2(NBLK * WORDS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NBLK-1:0] mask = '0;
    logic [DW-1:0]   rdata;
    logic swe, esu, ers, ev, dwr, rd, arm, clr, busy, done, fail;
    logic [NBLK-1:0] sel;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   wdata;

    always #10 clk = ~clk;

    flash_erase_seq #(
        .NBLK(NBLK), .WORDS(WORDS), .DW(DW), .N_ERASE(NE),
        .T_SWE_SEL(TX), .T_ESU_ERS(TY), .T_ERS(TE), .T_ERS_MAX(TZ),
        .T_ERS_ESU(TH1), .T_ESU_CLR(TH2), .T_EV_DWR(TDW),
        .T_DWR_RD(TRD), .T_EV_EXIT(TEX)
    ) u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(mask),
        .fl_rdata_i(rdata), .fl_swe_o(swe), .fl_esu_o(esu), .fl_ers_o(ers),
        .fl_ev_o(ev), .fl_blk_sel_o(sel), .fl_dwr_o(dwr), .fl_rd_o(rd),
        .fl_addr_o(addr), .fl_wdata_o(wdata), .wdt_arm_o(arm),
        .wdt_clr_o(clr), .busy_o(busy), .done_o(done), .fail_o(fail)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural array: a word reads erased once its block saw req[] pulses
    int req [NBLK*WORDS];
    int pulses [NBLK];
    logic ers_prev = 1'b0;

    always @(posedge clk) begin
        if (ers && !ers_prev) begin
            for (int b = 0; b < NBLK; b++) if (sel[b]) pulses[b]++;
        end
        ers_prev <= ers;
    end

    always_comb begin
        int a;
        a = int'(addr);
        rdata = (pulses[a / WORDS] >= req[a]) ? 16'hFFFF : 16'hFF7F;
    end

    // monitor sampled at negedge
    int cyc = 0;
    int t_swe, t_arm, t_esu, t_ers, t_ersf, t_esuf, t_ref, ref_off, t_dwr, t_rd, t_evf;
    int last_dwr_addr;
    bit first_sel;
    int dwr_log [64];
    int dwr_n, sel_log [8], sel_n, swe_rises, done_n, fail_n, busy_seen;
    logic p_swe = 0, p_esu = 0, p_ers = 0, p_ev = 0;
    logic [NBLK-1:0] p_sel = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy) busy_seen++;
            if (swe && !p_swe) begin t_swe = cyc; first_sel = 1; swe_rises++; end
            if (sel != p_sel && sel != '0) begin
                if (first_sel) chk(cyc - t_swe == TX, "R2 swe->select gap", cyc - t_swe, TX);
                else chk(cyc - t_evf == TEX, "R10 next block gap", cyc - t_evf, TEX);
                first_sel = 0;
                chk(arm == 1'b1, "R3 arm with select", int'(arm), 1);
                for (int b = 0; b < NBLK; b++) if (sel[b] && sel_n < 8) begin
                    sel_log[sel_n] = b; sel_n++;
                end
            end else if (arm) begin
                chk(cyc - t_evf == TEX, "R8 re-arm gap", cyc - t_evf, TEX);
            end
            if (arm) t_arm = cyc;
            if (esu && !p_esu) begin
                chk(cyc - t_arm == 1, "R3 arm->esu", cyc - t_arm, 1); t_esu = cyc;
            end
            if (ers && !p_ers) begin
                chk(cyc - t_esu == TY, "R4 esu->ers", cyc - t_esu, TY); t_ers = cyc;
            end
            if (!ers && p_ers) begin
                chk(cyc - t_ers == TE && cyc - t_ers <= TZ, "R4 ers length", cyc - t_ers, TE);
                t_ersf = cyc;
            end
            if (!esu && p_esu) begin
                chk(cyc - t_ersf == TH1, "R5 ers->esu fall", cyc - t_ersf, TH1); t_esuf = cyc;
            end
            if (ev && !p_ev) begin
                chk(cyc - t_esuf == TH2 && clr, "R5 esu fall->ev/clr", cyc - t_esuf, TH2);
                t_ref = cyc; ref_off = TDW;
            end
            if (dwr) begin
                chk(cyc - t_ref == ref_off, "R6 dummy write gap", cyc - t_ref, ref_off);
                chk(wdata == 16'hFFFF, "R6 dummy data", int'(wdata), 16'hFFFF);
                if (dwr_n < 64) begin dwr_log[dwr_n] = int'(addr); dwr_n++; end
                t_dwr = cyc; last_dwr_addr = int'(addr);
            end
            if (rd) begin
                chk(cyc - t_dwr == TRD && int'(addr) == last_dwr_addr, "R6 read gap/addr",
                    cyc - t_dwr, TRD);
                t_ref = cyc; ref_off = TDW + 1; t_rd = cyc;
            end
            if (!ev && p_ev) begin
                chk(cyc - t_rd == 1, "R7 ev drop after read", cyc - t_rd, 1); t_evf = cyc;
            end
            if (done) begin
                done_n++;
                if (swe_rises > 0 && p_swe) begin
                    chk(!swe && cyc - t_evf == TEX, "R10 done timing", cyc - t_evf, TEX);
                end
            end
            if (fail) begin
                fail_n++;
                chk(!swe && !esu && !ers && !ev && sel == '0 && cyc - t_rd == 1,
                    "R9 fail shutdown", cyc - t_rd, 1);
            end
        end
        p_swe = swe; p_esu = esu; p_ers = ers; p_ev = ev; p_sel = sel;
    end

    task automatic prep();
        for (int i = 0; i < NBLK*WORDS; i++) req[i] = 1;
        for (int b = 0; b < NBLK; b++) pulses[b] = 0;
        dwr_n = 0; sel_n = 0; swe_rises = 0; done_n = 0; fail_n = 0; busy_seen = 0;
    endtask

    task automatic kick(input logic [NBLK-1:0] m);
        @(negedge clk); start = 1'b1; mask = m;
        @(negedge clk); start = 1'b0; mask = '0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 8000; i++) begin
            if (done_n + fail_n > 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({swe, esu, ers, ev, dwr, rd, arm, clr, busy, done, fail} == '0 && sel == '0,
            "R1 outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({swe, esu, ers, ev, dwr, rd, arm, clr, busy, done, fail} == '0 && sel == '0,
            "R1 outputs after reset", int'(swe), 0);
    endtask

    task automatic t_single();
        prep();
        kick(4'b0001);
        wait_end();
        chk(done_n == 1 && fail_n == 0, "R10 single block done", done_n, 1);
        chk(pulses[0] == 1, "R7 one pulse when clean", pulses[0], 1);
        chk(dwr_n == WORDS, "R7 one dummy write per word", dwr_n, WORDS);
        for (int i = 0; i < WORDS; i++)
            chk(dwr_log[i] == i, "R7 address order", dwr_log[i], i);
    endtask

    task automatic t_multi();
        prep();
        kick(4'b1010);
        wait_end();
        chk(sel_n == 2 && sel_log[0] == 1 && sel_log[1] == 3, "R10 ascending order",
            sel_log[0] * 10 + sel_log[1], 13);
        chk(pulses[0] == 0 && pulses[2] == 0, "R10 unselected untouched",
            pulses[0] + pulses[2], 0);
        chk(pulses[1] == 1 && pulses[3] == 1, "R10 selected erased", pulses[1] + pulses[3], 2);
        chk(dwr_n == 2*WORDS && dwr_log[WORDS] == 3*WORDS, "R6 second block address",
            dwr_log[WORDS], 3*WORDS);
        chk(done_n == 1, "R10 single done", done_n, 1);
    endtask

    task automatic t_retry();
        prep();
        req[2*WORDS + 5] = 2;
        kick(4'b0100);
        wait_end();
        chk(pulses[2] == 2, "R8 re-erase count", pulses[2], 2);
        chk(dwr_n == WORDS + 1, "R8 dummy write total", dwr_n, WORDS + 1);
        chk(dwr_log[6] == 2*WORDS + 5, "R8 resume at failing word", dwr_log[6], 2*WORDS + 5);
        chk(dwr_log[5] == 2*WORDS + 5, "R8 failing word", dwr_log[5], 2*WORDS + 5);
        chk(done_n == 1 && fail_n == 0, "R8 done after retry", done_n, 1);
    endtask

    task automatic t_fail();
        prep();
        req[0] = NE + 2;
        kick(4'b0011);
        wait_end();
        chk(fail_n == 1 && done_n == 0, "R9 fail not done", fail_n, 1);
        chk(pulses[0] == NE, "R9 pulse limit", pulses[0], NE);
        chk(pulses[1] == 0, "R9 no later block", pulses[1], 0);
        chk(busy == 1'b0, "R9 busy ends", int'(busy), 0);
    endtask

    task automatic t_zero();
        prep();
        @(negedge clk); start = 1'b1; mask = '0;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b1, "R11 zero mask done", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(swe_rises == 0 && busy_seen == 0, "R11 zero mask no activity", swe_rises, 0);
    endtask

    task automatic t_busy();
        prep();
        kick(4'b0001);
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R11 busy during run", int'(busy), 1);
        kick(4'b1000);
        wait_end();
        chk(sel_n == 1 && sel_log[0] == 0, "R11 start while busy ignored", sel_n, 1);
        chk(pulses[3] == 0, "R11 block 3 untouched", pulses[3], 0);
        chk(swe_rises == 1 && done_n == 1, "R11 one run only", swe_rises, 1);
    endtask

    initial begin
        prep();
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_retry();
        t_fail();
        t_zero();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule